// File: doc/BRIEF.md
# Finite Burst Pulse Generator

This block produces a burst made of a set number of rectangular pulses. A free-running up-counter steps once per clock. It counts from zero to a period limit and then wraps. The pulse output uses set/reset behaviour: it is set when the counter passes a compare threshold and cleared on the wrap. Each period therefore carries one pulse whose width is the period limit minus the threshold.

A burst counter counts wraps and stops the train after the programmed number of pulses. A count of zero runs the train until `stop` is raised.

Software presents the period limit, the threshold and the pulse count on the inputs, then strobes `start`. All three values are captured at that moment. `busy` stays high while the train runs. `done` marks the normal end of a finite burst.

With a 1 MHz clock, a limit of 999, a threshold of 979 and any count give 20 µs pulses at 1 kHz.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset, `busy`, `done` and `pulse_out` are all 0.
- R2: A `start` sampled while idle clears the internal count to 0 and raises `busy` in the next cycle. The count then steps by one each cycle up to `period_lim` and returns to 0, so one period lasts `period_lim`+1 cycles.
- R3: Number the busy cycles k = 0, 1, 2, … from the first cycle after `start`, and let c = k mod (`period_lim`+1). `pulse_out` is 1 exactly when c > `cmp_lim`. The pulse rises after the compare match, falls at the wrap, and lasts `period_lim`−`cmp_lim` cycles.
- R4: When `cmp_lim` equals `period_lim`, the set and the reset coincide at the wrap. The output is then a one-cycle pulse in the cycle where c = `period_lim`.
- R5: When `cmp_lim` is greater than `period_lim`, `pulse_out` stays 0 for the whole burst.
- R6: With `pulse_cnt` = N > 0, `busy` stays high for exactly N·(`period_lim`+1) cycles. In the following cycle `busy` is 0, `pulse_out` is 0 and `done` is 1. `done` is 1 for that single cycle only.
- R7: With `pulse_cnt` = 0, the train repeats without end. A `stop` sampled while busy clears `busy` and `pulse_out` in the next cycle without pulsing `done`.
- R8: A `start` sampled while `busy` is 1 has no effect on the running burst.
- R9: `period_lim`, `cmp_lim` and `pulse_cnt` are used only at the accepted `start`. Changes to them during a burst do not alter its waveform or length.
- R10: `pulse_out` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one count step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_lim | input | TW | Counter top value (desired period minus one) |
| cmp_lim | input | TW | Threshold whose match sets the output |
| pulse_cnt | input | NW | Pulses per burst; 0 means continuous |
| start | input | 1 | Begin a burst when idle |
| stop | input | 1 | Abort a running burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle marker at the end of a finite burst |
| pulse_out | output | 1 | Pulse train |

## Verification
The bench compares every busy cycle against the position-in-period formula. A rise one cycle early or late, or a fall placed before the wrap instead of after it, therefore shows up as a width error.

Three threshold cases are covered: equal to the limit, where a design that lets reset win would emit nothing; above the limit, where a loose compare would produce stray pulses; and the 20-of-1000 target.

A burst counter that is off by one would lengthen or shorten the burst by a whole period, and the bench would see `busy` fall at the wrong cycle.

A retriggered `start` and rewritten inputs in mid-burst would lengthen the burst or distort the pulses if the design did not latch its settings at `start`. The continuous mode checks that `stop` halts cleanly without a `done`.

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
  parameter int TW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period_lim,
  input  logic [TW-1:0] cmp_lim,
  input  logic [NW-1:0] pulse_cnt,
  input  logic          start,
  input  logic          stop,
  output logic          busy,
  output logic          done,
  output logic          pulse_out
);
  logic [TW-1:0] per_q, cmp_q, cnt_q;
  logic [NW-1:0] len_q, seen_q;
  logic          busy_q, done_q, out_q;

  logic          go, wrap, last, busy_n, out_n;
  logic [TW-1:0] cnt_n, per_n, cmp_n;
  logic [NW-1:0] seen_n;

  assign go     = start && !busy_q;
  assign wrap   = busy_q && (cnt_q == per_q);
  assign last   = wrap && (len_q != '0) && (seen_q == len_q - 1'b1);
  assign per_n  = go ? period_lim : per_q;
  assign cmp_n  = go ? cmp_lim : cmp_q;
  assign busy_n = go ? 1'b1 : (busy_q && !stop && !last);

  always_comb begin
    if (go)          cnt_n = '0;
    else if (!busy_q) cnt_n = cnt_q;
    else if (wrap)   cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  assign seen_n = go ? '0 : (wrap ? seen_q + 1'b1 : seen_q);
  assign out_n  = busy_n && ((cnt_n > cmp_n) ||
                             ((cmp_n == per_n) && (cnt_n == per_n)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmp_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      seen_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (go) begin
        per_q <= period_lim;
        cmp_q <= cmp_lim;
        len_q <= pulse_cnt;
      end
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      busy_q <= busy_n;
      done_q <= last && !stop;
      out_q  <= out_n;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign pulse_out = out_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= per_q) else $error("count above limit"); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && cnt_q != '0) |-> cnt_q == $past(cnt_q) + 1'b1)
    else $error("count skipped"); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done too long"); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))) else $error("done misplaced"); // R6
  AST_CMP_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmp_q > per_q) |-> !out_q) else $error("pulse with cmp over limit"); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(per_q) && $stable(cmp_q) && $stable(len_q)))
    else $error("config changed mid-burst"); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !out_q) else $error("output high while idle"); // R10
endmodule

// File: tb/sim_pulse_burst_gen.sv
module sim_pulse_burst_gen;
  localparam int TW = 16;
  localparam int NW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] period_lim = '0, cmp_lim = '0;
  logic [NW-1:0] pulse_cnt = '0;
  logic start = 1'b0, stop = 1'b0;
  logic busy, done, pulse_out;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_burst_gen #(.TW(TW), .NW(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .period_lim(period_lim), .cmp_lim(cmp_lim),
    .pulse_cnt(pulse_cnt), .start(start), .stop(stop),
    .busy(busy), .done(done), .pulse_out(pulse_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model(input int k, input int p, input int c);
    int ph = k % (p + 1);
    return (ph > c) || (c == p && ph == p);
  endfunction

  // Runs a burst; optionally retriggers start and rewrites inputs mid-burst.
  task automatic run_burst(input int p, input int c, input int n,
                           input bit disturb, input string req);
    int wrong = 0, highs = 0, len;
    period_lim = p[TW-1:0]; cmp_lim = c[TW-1:0]; pulse_cnt = n[NW-1:0];
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    len = n * (p + 1);
    for (int k = 0; k < len; k++) begin
      if (disturb && k == 3) begin
        start = 1'b1; period_lim = 3; cmp_lim = 0; pulse_cnt = 7;
      end
      if (disturb && k == 4) start = 1'b0;
      if (!busy || pulse_out !== model(k, p, c)) begin
        if (wrong == 0)
          $display("FAIL %s cycle %0d busy=%0b actual=%0b expected=%0b",
                   req, k, busy, pulse_out, model(k, p, c));
        wrong++;
      end
      if (pulse_out) highs++;
      @(negedge clk);
    end
    checks++; if (wrong != 0) fails++;
    chk(!busy, "R6 busy end", busy, 0);
    chk(done, "R6 done at end", done, 1);
    chk(!pulse_out, "R10 out low at end", pulse_out, 0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
    if (c < p)       chk(highs == n * (p - c), {req, " R3 width"}, highs, n * (p - c));
    else if (c == p) chk(highs == n, "R4 one-tick", highs, n);
    else             chk(highs == 0, "R5 never high", highs, 0);
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    chk(!pulse_out, "R1 out", pulse_out, 0);
  endtask

  task automatic t_continuous(input int p, input int c);
    int wrong = 0, len = 4 * (p + 1) + 2;
    period_lim = p[TW-1:0]; cmp_lim = c[TW-1:0]; pulse_cnt = '0;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (!busy || pulse_out !== model(k, p, c)) wrong++;
      @(negedge clk);
    end
    chk(wrong == 0, "R7 continuous train", wrong, 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!busy, "R7 stop clears busy", busy, 0);
    chk(!pulse_out, "R7 stop clears out", pulse_out, 0);
    chk(!done, "R7 no done on stop", done, 0);
    @(negedge clk);
    chk(!done && !busy, "R7 stays idle", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_burst(9, 5, 3, 1'b0, "R2 R3 basic");
    run_burst(49, 29, 2, 1'b0, "R3 20-tick");
    run_burst(7, 12, 2, 1'b0, "R5 cmp over");
    run_burst(5, 5, 3, 1'b0, "R4 cmp equal");
    run_burst(11, 2, 2, 1'b1, "R8 R9 disturb");
    t_continuous(6, 3);
    run_burst(999, 979, 2, 1'b0, "R3 target");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule